// File: doc/BRIEF.md
# Random-Seeded Key Capture Unit

This block owns the 64-bit secret that the address and data scramblers use. Software never writes the key value. The loader asks for a fresh key by sending a key-generation command. The block then clears its collector and takes in one bit from a random-bit source on every cycle in which that source flags a valid bit. When 64 bits have arrived, the collected word replaces the key. In the same cycle the block signals completion and permits the external program load to start.

The key output always drives the scramblers, and no bypass setting exists. While a security-lock input is high, key-generation requests are refused and the current key stays as it is. A second command ends the load window. Any other command code changes nothing and reports an error.

Top module: `keyseed_mgr`

## Requirements
- R1: After reset, `key_out` is zero and `load_en`, `cmd_busy`, `cmd_done` and `cmd_err` are all low.
- R2: When the unit is idle and `sec_lock` is low, a key-generation command (code 4'hA) makes `cmd_busy` go high and `load_en` go low on the next clock edge.
- R3: During a capture the unit counts only the cycles in which `rnd_valid` is high. The first collected bit becomes `key_out[63]` and the last becomes `key_out[0]`. `key_out` keeps its old value until the capture completes. Valid bits that arrive while the unit is idle are discarded.
- R4: On the clock edge that samples the 64th valid bit, `key_out` takes the new word, `load_en` goes high, `cmd_done` pulses for one cycle with `cmd_err` low, and `cmd_busy` falls. `load_en` is never high while `cmd_busy` is high.
- R5: While `sec_lock` is high, a key-generation command starts no capture and leaves `key_out` and `load_en` unchanged. One cycle later the unit answers with `cmd_done` and `cmd_err` both high.
- R6: An end-of-load command (code 4'h6) clears `load_en` and answers one cycle later with `cmd_done` high and `cmd_err` low.
- R7: Any other command code leaves `key_out` and `load_en` unchanged and answers one cycle later with `cmd_done` and `cmd_err` both high.
- R8: Commands that arrive while `cmd_busy` is high are ignored. They produce no `cmd_done` and do not disturb the capture.
- R9: `key_out` changes only in the cycle in which a successful capture reports completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command strobe |
| cmd_code | input | 4 | Command code |
| cmd_busy | output | 1 | High while a capture is in progress |
| cmd_done | output | 1 | One-cycle completion pulse |
| cmd_err | output | 1 | Qualifies `cmd_done`: request refused or code unknown |
| rnd_bit | input | 1 | Random data bit |
| rnd_valid | input | 1 | `rnd_bit` is valid this cycle |
| sec_lock | input | 1 | Security lock; refuses key generation while high |
| key_out | output | 64 | Key to the scramblers |
| load_en | output | 1 | External program load permitted |

## Verification
Every response is registered. A command sampled on one edge is visible after that same edge: `cmd_busy` for an accepted key generation, and `cmd_done`/`cmd_err` for any other command. The new key, `load_en` and the completion pulse all appear on the edge that samples the 64th valid bit. The bench drives inputs at the falling edge and reads outputs at the next falling edge, which is exactly one rising edge after the stimulus. It checks the completion pulse once at that point and checks it again one cycle later to confirm it has dropped. Bits are sent both back-to-back and with idle gaps. A command is also injected in the middle of a capture to show that the capture is not disturbed.

// File: rtl/keymgr_pkg.sv
package keymgr_pkg;
    typedef enum logic [0:0] {
        ST_IDLE   = 1'b0,
        ST_GATHER = 1'b1
    } mgr_state_e;

    typedef enum logic [1:0] {
        CMD_KEYGEN  = 2'd0,
        CMD_ENDLOAD = 2'd1,
        CMD_OTHER   = 2'd2
    } cmd_kind_e;
endpackage

// File: rtl/key_cmd_decode.sv
module key_cmd_decode
    import keymgr_pkg::*;
#(
    parameter int                CMD_W        = 4,
    parameter logic [CMD_W-1:0]  KEYGEN_CODE  = 4'hA,
    parameter logic [CMD_W-1:0]  ENDLOAD_CODE = 4'h6
) (
    input  logic [CMD_W-1:0] code,
    output cmd_kind_e        kind
);
    always_comb begin
        if (code == KEYGEN_CODE) begin
            kind = CMD_KEYGEN;
        end else if (code == ENDLOAD_CODE) begin
            kind = CMD_ENDLOAD;
        end else begin
            kind = CMD_OTHER;
        end
    end
endmodule

// File: rtl/key_bit_collector.sv
module key_bit_collector #(
    parameter int WORD_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              sample_en,
    input  logic              bit_in,
    output logic [WORD_W-1:0] word_full,
    output logic              last
);
    localparam int CNT_W = $clog2(WORD_W);

    typedef struct packed {
        logic [WORD_W-1:0] shreg;
        logic [CNT_W-1:0]  cnt;
    } coll_t;

    coll_t col_d, col_q;

    always_comb begin
        col_d = col_q;
        if (clear) begin
            col_d.cnt = '0;
        end else if (sample_en) begin
            col_d.shreg = {col_q.shreg[WORD_W-2:0], bit_in};
            col_d.cnt   = col_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            col_q <= '0;
        end else begin
            col_q <= col_d;
        end
    end

    assign word_full = {col_q.shreg[WORD_W-2:0], bit_in};
    assign last      = sample_en && (col_q.cnt == CNT_W'(WORD_W - 1));

    // R3: the count moves only on a valid sample or a clear
    p_count_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!sample_en && !clear) |=> $stable(col_q.cnt));
endmodule

// File: rtl/keyseed_mgr.sv
module keyseed_mgr
    import keymgr_pkg::*;
#(
    parameter int               KEY_W        = 64,
    parameter int               CMD_W        = 4,
    parameter logic [CMD_W-1:0] KEYGEN_CODE  = 4'hA,
    parameter logic [CMD_W-1:0] ENDLOAD_CODE = 4'h6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [CMD_W-1:0] cmd_code,
    output logic             cmd_busy,
    output logic             cmd_done,
    output logic             cmd_err,
    input  logic             rnd_bit,
    input  logic             rnd_valid,
    input  logic             sec_lock,
    output logic [KEY_W-1:0] key_out,
    output logic             load_en
);
    typedef struct packed {
        mgr_state_e       st;
        logic [KEY_W-1:0] key;
        logic             load_en;
        logic             done;
        logic             err;
    } mgr_t;

    mgr_t             m_d, m_q;
    cmd_kind_e        kind;
    logic             coll_clear;
    logic             coll_en;
    logic             coll_last;
    logic [KEY_W-1:0] coll_word;

    key_cmd_decode #(
        .CMD_W        (CMD_W),
        .KEYGEN_CODE  (KEYGEN_CODE),
        .ENDLOAD_CODE (ENDLOAD_CODE)
    ) i_decode (
        .code (cmd_code),
        .kind (kind)
    );

    key_bit_collector #(
        .WORD_W (KEY_W)
    ) i_collect (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (coll_clear),
        .sample_en (coll_en),
        .bit_in    (rnd_bit),
        .word_full (coll_word),
        .last      (coll_last)
    );

    always_comb begin
        m_d        = m_q;
        m_d.done   = 1'b0;
        m_d.err    = 1'b0;
        coll_clear = 1'b0;
        coll_en    = 1'b0;
        case (m_q.st)
            ST_IDLE: begin
                if (cmd_valid) begin
                    case (kind)
                        CMD_KEYGEN: begin
                            if (sec_lock) begin
                                m_d.done = 1'b1;
                                m_d.err  = 1'b1;
                            end else begin
                                m_d.st      = ST_GATHER;
                                m_d.load_en = 1'b0;
                                coll_clear  = 1'b1;
                            end
                        end
                        CMD_ENDLOAD: begin
                            m_d.load_en = 1'b0;
                            m_d.done    = 1'b1;
                        end
                        default: begin
                            m_d.done = 1'b1;
                            m_d.err  = 1'b1;
                        end
                    endcase
                end
            end
            ST_GATHER: begin
                coll_en = rnd_valid;
                if (coll_last) begin
                    m_d.key     = coll_word;
                    m_d.load_en = 1'b1;
                    m_d.done    = 1'b1;
                    m_d.st      = ST_IDLE;
                end
            end
            default: m_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_q <= '{st: ST_IDLE, key: '0, load_en: 1'b0, done: 1'b0, err: 1'b0};
        end else begin
            m_q <= m_d;
        end
    end

    assign cmd_busy = (m_q.st == ST_GATHER);
    assign cmd_done = m_q.done;
    assign cmd_err  = m_q.err;
    assign key_out  = m_q.key;
    assign load_en  = m_q.load_en;

    // R4: loading is never permitted during a capture
    p_noload_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (m_q.st == ST_GATHER) |-> !m_q.load_en);

    // R5: a locked key-generation request is refused
    p_lock_refuses_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (m_q.st == ST_IDLE && cmd_valid && sec_lock && kind == CMD_KEYGEN)
        |=> (m_q.st == ST_IDLE && m_q.done && m_q.err));

    // R7: an error flag only ever accompanies a completion
    p_err_with_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        m_q.err |-> m_q.done);

    // R8: a capture runs until its last bit regardless of commands
    p_busy_ignores_cmd_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (m_q.st == ST_GATHER && !coll_last) |=> (m_q.st == ST_GATHER));

    // R9: the key moves only with a clean completion
    p_key_only_on_capture_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(m_q.key) |-> (m_q.done && !m_q.err));
endmodule

// File: tb/test_keyseed_mgr.sv
module test_keyseed_mgr;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [3:0]  cmd_code = 4'h0;
    logic        cmd_busy, cmd_done, cmd_err;
    logic        rnd_bit = 1'b0;
    logic        rnd_valid = 1'b0;
    logic        sec_lock = 1'b0;
    logic [63:0] key_out;
    logic        load_en;

    int checks = 0;
    int errors = 0;

    localparam logic [3:0] C_KEYGEN  = 4'hA;
    localparam logic [3:0] C_ENDLOAD = 4'h6;

    always #2 clk = ~clk;

    keyseed_mgr i_keyseed_mgr (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .cmd_busy(cmd_busy), .cmd_done(cmd_done), .cmd_err(cmd_err),
        .rnd_bit(rnd_bit), .rnd_valid(rnd_valid), .sec_lock(sec_lock),
        .key_out(key_out), .load_en(load_en)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send_cmd(input logic [3:0] code);
        cmd_valid = 1'b1;
        cmd_code  = code;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 key", key_out, 64'h0);
        chk("R1 load_en", {63'h0, load_en}, 64'h0);
        chk("R1 busy", {63'h0, cmd_busy}, 64'h0);
        chk("R1 done", {62'h0, cmd_done, cmd_err}, 64'h0);
    endtask

    task automatic t_unknown(input logic [3:0] code, input logic [63:0] key_exp, input logic le_exp);
        send_cmd(code);
        chk("R7 done/err", {62'h0, cmd_done, cmd_err}, 64'h3);
        chk("R7 key held", key_out, key_exp);
        chk("R7 load_en held", {63'h0, load_en}, {63'h0, le_exp});
        @(negedge clk);
        chk("R7 done drops", {63'h0, cmd_done}, 64'h0);
    endtask

    task automatic t_capture(input logic [63:0] pat, input logic [63:0] old_key, input bit gaps);
        // junk strobes while idle must not enter the key (R3)
        for (int j = 0; j < 5; j++) begin
            rnd_valid = 1'b1; rnd_bit = ~pat[j];
            @(negedge clk);
        end
        rnd_valid = 1'b0;
        send_cmd(C_KEYGEN);
        chk("R2 busy", {63'h0, cmd_busy}, 64'h1);
        chk("R2 load_en low", {63'h0, load_en}, 64'h0);
        for (int i = 63; i >= 0; i--) begin
            if (gaps && (i % 3 == 0)) begin
                rnd_valid = 1'b0; rnd_bit = ~pat[i];
                @(negedge clk);
            end
            if (i == 31) begin
                rnd_valid = 1'b0;
                send_cmd(C_ENDLOAD);
                chk("R8 no done while busy", {63'h0, cmd_done}, 64'h0);
                chk("R8 still busy", {63'h0, cmd_busy}, 64'h1);
                chk("R3 key unchanged mid-capture", key_out, old_key);
            end
            rnd_valid = 1'b1; rnd_bit = pat[i];
            @(negedge clk);
            rnd_valid = 1'b0;
        end
        chk("R3 key value", key_out, pat);
        chk("R4 load_en", {63'h0, load_en}, 64'h1);
        chk("R4 done/err", {62'h0, cmd_done, cmd_err}, 64'h2);
        chk("R4 busy low", {63'h0, cmd_busy}, 64'h0);
        @(negedge clk);
        chk("R4 done one cycle", {63'h0, cmd_done}, 64'h0);
    endtask

    task automatic t_endload();
        send_cmd(C_ENDLOAD);
        chk("R6 load_en cleared", {63'h0, load_en}, 64'h0);
        chk("R6 done/err", {62'h0, cmd_done, cmd_err}, 64'h2);
        @(negedge clk);
    endtask

    task automatic t_lock(input logic [63:0] key_exp, input logic le_exp);
        sec_lock = 1'b1;
        send_cmd(C_KEYGEN);
        chk("R5 done/err", {62'h0, cmd_done, cmd_err}, 64'h3);
        chk("R5 not busy", {63'h0, cmd_busy}, 64'h0);
        for (int i = 0; i < 70; i++) begin
            rnd_valid = 1'b1; rnd_bit = i[0];
            @(negedge clk);
        end
        rnd_valid = 1'b0;
        chk("R5 key held", key_out, key_exp);
        chk("R5 load_en held", {63'h0, load_en}, {63'h0, le_exp});
        sec_lock = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_unknown(4'h3, 64'h0, 1'b0);
        t_capture(64'hA5C3_1F00_DEAD_BEEF, 64'h0, 1'b0);
        t_unknown(4'hF, 64'hA5C3_1F00_DEAD_BEEF, 1'b1);
        t_lock(64'hA5C3_1F00_DEAD_BEEF, 1'b1);
        t_endload();
        t_capture(64'h0123_4567_89AB_CDEF, 64'hA5C3_1F00_DEAD_BEEF, 1'b1);
        t_endload();
        t_lock(64'h0123_4567_89AB_CDEF, 1'b0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule